// File: doc/BRIEF.md
# I2C EEPROM-Emulating Target

This block is an I2C target that looks to a bus controller like a small serial EEPROM at one fixed 7-bit device address. It watches oversampled SCL and SDA levels on the system clock and answers through a single open-drain pull-down enable. The bus's own START, repeated START and STOP conditions frame every exchange.

The target holds a word-address pointer that persists between transfers. A write-direction transfer first loads the pointer from one or two word-address bytes, then stores any further bytes at successive locations. A read-direction transfer returns bytes from the pointer onward. The pointer advances after every byte in either direction and wraps from the top location to zero. The usual random read is a write of the word address, a repeated START, and a read. It works unchanged because the pointer survives both the repeated START and a STOP.

Each transfer begins with the target as a receiver. It becomes a transmitter only after it has acknowledged an address byte whose direction bit asks for a read. It returns to a quiet receiver when the controller refuses a data byte or ends the transfer. There is no host-side data port: the memory is reached only over the bus. Valid/ready back-pressure therefore has no place here, and the bus pins stay plain level signals.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A START (SDA falls while SCL is high) or STOP (SDA rises while SCL is high) is recognised in every state and overrides it. A STOP leaves the target idle with SDA released. A START, even in the middle of a byte, returns it to address reception and discards the partial byte.
- R2: An address byte carries the device address (default 7'h50) in bits 7:1, sent MSB first, and the direction in bit 0 (0 = write, 1 = read). On a match the target pulls SDA low for the ninth SCL clock.
- R3: A non-matching address byte gets no acknowledge. The target then neither drives SDA nor stores anything until the next START or STOP.
- R4: In a write-direction transfer the bytes after the address load the pointer. There is one byte when the memory depth is at most 256, and two bytes, high byte first, for larger depths. Each byte is acknowledged.
- R5: Every byte after the word address is acknowledged and stored at the pointer location, and the pointer then advances by one.
- R6: After a read-direction address the target drives the byte at the pointer MSB first, changing SDA after each SCL fall. The pointer advances once per byte sent.
- R7: The pointer keeps its value across a repeated START and across a STOP followed by a new START. A read continues from where the last transfer left it.
- R8: The pointer wraps from the top location (depth minus one) to location 0, in both writes and reads.
- R9: A controller NACK after a read byte makes the target release SDA at once and go idle. It drives nothing until the next START.
- R10: Outside a read phase the target drives SDA only in acknowledge slots, and it changes SDA only while SCL is low.
- R11: After reset SDA is released and every memory location reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
Each target response lags the bus edge that causes it by about four system clocks: two synchroniser stages, the edge register, and the state register. The controller model holds every SCL phase for eight clocks and samples the line only at the end of a phase. Acknowledges are therefore read while SCL is high, well after the target has had time to set them, and read data is taken at the end of the high phase. Each quiet-bus check, after a NACK, STOP or rejected address, falls eight clocks after the SCL fall. That is late enough that a wrongly driven next bit would already be visible.

// File: rtl/eetgt_pkg.sv
package eetgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    RK_DEVADDR,
    RK_WORDADDR,
    RK_WDATA
  } rx_kind_e;

endpackage

// File: rtl/eetgt_bus_sync.sv
module eetgt_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] scl_q;
  logic [1:0] sda_q;
  logic       scl_d;
  logic       sda_d;

  // two-stage synchronisers, idle-high reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end
  end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eetgt_mem.sv
module eetgt_mem #(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data
);

  logic [7:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[g] <= 8'h00;
      else if (wr_en && (addr == AW'(g)))
        word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[addr];

endmodule

// File: rtl/eetgt_ctrl.sv
module eetgt_ctrl
  import eetgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WA_BYTES = (DEPTH > 256) ? 2 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wr_data,
  output logic          sda_oe
);

  localparam logic WA_LAST = 1'(WA_BYTES - 1);

  tgt_state_e    state;
  rx_kind_e      kind;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic          sda_oe_r;
  logic [AW-1:0] ptr;
  logic [AW-1:0] ptr_nxt;
  logic          wa_idx;
  logic          rnw;
  logic          master_ack;
  logic          byte_done;

  assign ptr_nxt   = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign byte_done = scl_fall && (bitcnt == 4'd8);

  assign mem_wr_en   = !start_det && !stop_det && (state == ST_RECV) &&
                       (kind == RK_WDATA) && byte_done;
  assign mem_addr    = ptr;
  assign mem_wr_data = shreg;
  assign sda_oe      = sda_oe_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= RK_DEVADDR;
      bitcnt     <= 4'd0;
      shreg      <= 8'h00;
      sda_oe_r   <= 1'b0;
      ptr        <= '0;
      wa_idx     <= 1'b0;
      rnw        <= 1'b0;
      master_ack <= 1'b0;
    end else if (start_det) begin
      state    <= ST_RECV;
      kind     <= RK_DEVADDR;
      bitcnt   <= 4'd0;
      sda_oe_r <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      bitcnt   <= 4'd0;
      sda_oe_r <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RECV: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= 4'd0;
            unique case (kind)
              RK_DEVADDR: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rnw      <= shreg[0];
                  sda_oe_r <= 1'b1;
                  state    <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              RK_WORDADDR: begin
                ptr      <= AW'({ptr, shreg});
                sda_oe_r <= 1'b1;
                state    <= ST_ACK;
              end
              default: begin
                ptr      <= ptr_nxt;
                sda_oe_r <= 1'b1;
                state    <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= 4'd0;
            if (kind == RK_DEVADDR && rnw) begin
              shreg    <= mem_rd_data;
              ptr      <= ptr_nxt;
              sda_oe_r <= ~mem_rd_data[7];
              state    <= ST_TX;
            end else begin
              sda_oe_r <= 1'b0;
              state    <= ST_RECV;
              if (kind == RK_DEVADDR) begin
                kind   <= RK_WORDADDR;
                wa_idx <= 1'b0;
              end else if (kind == RK_WORDADDR) begin
                if (wa_idx == WA_LAST) kind <= RK_WDATA;
                else                   wa_idx <= wa_idx + 1'b1;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe_r <= 1'b0;
              state    <= ST_TXACK;
            end else begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_oe_r <= ~shreg[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            master_ack <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt <= 4'd0;
            if (master_ack) begin
              shreg    <= mem_rd_data;
              ptr      <= ptr_nxt;
              sda_oe_r <= ~mem_rd_data[7];
              state    <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_r) && !$past(start_det) && !$past(stop_det)) |-> !scl_s) // R10
    else $error("SDA enable changed while SCL high");

  AST_RECV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV) |-> !sda_oe_r) // R10
    else $error("SDA driven while receiving bits");

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe_r)) // R1
    else $error("STOP did not idle the target");

  AST_START_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> $stable(ptr)) // R7
    else $error("pointer changed on START");

  AST_NACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TXACK && scl_fall && !master_ack && !start_det && !stop_det)
      |=> (state == ST_IDLE && !sda_oe_r)) // R9
    else $error("NACK did not release the bus");

  AST_MISMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV && kind == RK_DEVADDR && byte_done && !start_det &&
     !stop_det && shreg[7:1] != DEV_ADDR) |=> (state == ST_IDLE && !sda_oe_r)) // R3
    else $error("foreign address acknowledged");

  AST_WRITE_BUMPS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (ptr != $past(ptr))) // R5
    else $error("pointer did not advance after a write");

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int MEM_DEPTH = 256,
  localparam int AW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);

  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;

  eetgt_bus_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eetgt_ctrl #(
    .DEV_ADDR (DEV_ADDR),
    .DEPTH    (MEM_DEPTH)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .mem_rd_data (rd_data),
    .mem_wr_en   (wr_en),
    .mem_addr    (addr),
    .mem_wr_data (wr_data),
    .sda_oe      (sda_pull)
  );

  eetgt_mem #(
    .DEPTH (MEM_DEPTH)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

endmodule

// File: tb/test_eeprom_i2c_target.sv
module test_eeprom_i2c_target;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_pull;
  logic sda_line;

  assign sda_line = ~(m_sda_low | sda_pull);

  always #(CLK_PERIOD / 2) clk = ~clk;

  eeprom_i2c_target i_eeprom_i2c_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (m_scl),
    .sda_in   (sda_line),
    .sda_pull (sda_pull)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] model_mem [256];
  int mptr = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string tag_q[$];
  event got_ev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        automatic logic [7:0] a = got_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(a == e, t, a, e);
      end
    end
  end

  task automatic bus_start();
    m_sda_low = 1'b0; tick(Q);
    m_scl = 1'b1;     tick(Q);
    m_sda_low = 1'b1; tick(Q);
    m_scl = 1'b0;     tick(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(Q);
    m_scl = 1'b1;     tick(Q);
    m_sda_low = 1'b0; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, output bit drove);
    drove = 1'b0;
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda_low = ~b[i]; tick(Q);
      m_scl = 1'b1;      tick(Q);
      if (sda_pull) drove = 1'b1;
      tick(Q);
      m_scl = 1'b0;      tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, output bit drove);
    send_bits(b, 8, drove);
    m_sda_low = 1'b0; tick(Q);
    m_scl = 1'b1;     tick(Q);
    acked = ~sda_line;
    tick(Q);
    m_scl = 1'b0;     tick(Q);
  endtask

  task automatic recv_byte(input bit ack, input bit push, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      m_scl = 1'b0;
    end
    tick(Q);
    m_sda_low = ack; tick(Q);
    m_scl = 1'b1;    tick(2 * Q);
    m_scl = 1'b0;
    m_sda_low = 1'b0; tick(Q);
    if (push) begin
      got_q.push_back(b);
      -> got_ev;
    end
  endtask

  task automatic addr_phase(input logic [6:0] dev, input bit rd, input string req, input bit want);
    bit a, d;
    send_byte({dev, rd}, a, d);
    chk(a == want, req, a, want);
    chk(!d, "R10", d, 0);
  endtask

  task automatic write_txn(input logic [7:0] wa, input logic [7:0] d [4], input int n);
    bit a, dr;
    bus_start();
    addr_phase(DEV, 1'b0, "R2", 1'b1);
    send_byte(wa, a, dr);
    chk(a, "R4", a, 1);
    mptr = wa;
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a, dr);
      chk(a && !dr, "R5", {dr, a}, 1);
      model_mem[mptr] = d[k];
      mptr = (mptr + 1) % 256;
    end
    bus_stop();
    tick(Q);
    chk(sda_pull == 1'b0, "R1", sda_pull, 0);
  endtask

  task automatic read_data(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model_mem[mptr]);
      tag_q.push_back(req);
      mptr = (mptr + 1) % 256;
      recv_byte(k < n - 1, 1'b1, b);
    end
    // after the NACK the bus must stay released
    chk(sda_pull == 1'b0, "R9", sda_pull, 0);
    bus_stop();
  endtask

  task automatic random_read(input logic [7:0] wa, input int n, input string req);
    bit a, dr;
    bus_start();
    addr_phase(DEV, 1'b0, "R2", 1'b1);
    send_byte(wa, a, dr);
    chk(a, "R4", a, 1);
    mptr = wa;
    bus_start();
    addr_phase(DEV, 1'b1, "R6", 1'b1);
    read_data(n, req);
  endtask

  task automatic current_read(input int n, input string req);
    bus_start();
    addr_phase(DEV, 1'b1, "R7", 1'b1);
    read_data(n, req);
  endtask

  initial begin
    bit a, dr;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk(sda_pull == 1'b0, "R11", sda_pull, 0);

    // reset contents read as zero
    random_read(8'h80, 1, "R11");

    // sequential write then random read
    write_txn(8'h10, '{8'h11, 8'h22, 8'h33, 8'h44}, 4);
    random_read(8'h10, 3, "R6");
    // continue from pointer after STOP
    current_read(1, "R7");

    // foreign address with write bit: ignored
    bus_start();
    addr_phase(7'h51, 1'b0, "R3", 1'b0);
    send_byte(8'h10, a, dr);
    chk(!a && !dr, "R3", {dr, a}, 0);
    send_byte(8'h99, a, dr);
    chk(!a && !dr, "R3", {dr, a}, 0);
    bus_stop();
    random_read(8'h10, 1, "R3");

    // foreign address with read bit: never drives
    bus_start();
    addr_phase(7'h23, 1'b1, "R3", 1'b0);
    recv_byte(1'b0, 1'b0, b);
    chk(b == 8'hFF, "R3", b, 8'hFF);
    bus_stop();

    // wrap at the top
    write_txn(8'hFE, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, 3);
    current_read(1, "R8");
    random_read(8'hFE, 3, "R8");

    // pointer set by word address alone survives STOP
    write_txn(8'h12, '{8'h00, 8'h00, 8'h00, 8'h00}, 0);
    current_read(2, "R7");

    // START in the middle of a byte
    write_txn(8'h20, '{8'h55, 8'h00, 8'h00, 8'h00}, 1);
    bus_start();
    addr_phase(DEV, 1'b0, "R2", 1'b1);
    send_byte(8'h21, a, dr);
    chk(a, "R4", a, 1);
    mptr = 8'h21;
    send_bits(8'h77, 3, dr);
    bus_start();
    addr_phase(DEV, 1'b1, "R1", 1'b1);
    read_data(1, "R1");
    random_read(8'h20, 1, "R5");

    tick(4 * Q);
    chk(exp_q.size() == 0 && got_q.size() == 0, "R6", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule